// File: doc/BRIEF.md
# Clear-Channel Serial Transmitter with Idle Fill

This block turns a stream of bytes into a one-bit serial line. Bytes come from the read side of a transmit FIFO, which sits outside the block. Each transmit clock enable moves the line on by one bit. The block sends the bytes exactly as it receives them. It adds no opening or closing flags, no zero-bit stuffing and no checksum, so the far end receives the user bytes without change.

At every byte boundary the block looks at the FIFO. If it holds data, the head byte is loaded and the FIFO is told to drop it. If the FIFO is empty, a fill byte goes out in its place. The fill byte depends on the pattern-match mode input:
- With the mode input set, the fill is the programmable idle character.
- With the mode input clear, the fill is all ones.

The choice is made only at a boundary, so a byte that has started is always sent to the end.

Top module: `clear_channel_tx`

## Requirements
- R1: During and right after a synchronous active-high reset, `tx_bit` is 1 and `fifo_rd` is 0. The first `bit_en` after reset starts a new byte.
- R2: Bits leave least-significant bit first. `tx_bit` changes only on a clock edge where `bit_en` is 1, and it holds its value while `bit_en` is 0.
- R3: User bytes appear on the line bit for bit, with no inserted, removed or framing bits. Bytes follow each other with no gap, so a value such as 8'h7E or 8'hFF is treated as plain data.
- R4: At a byte boundary with `fifo_empty`=1 and `match_en`=1, the byte sent is `idle_char`.
- R5: At a byte boundary with `fifo_empty`=1 and `match_en`=0, the byte sent is all ones, whatever `idle_char` holds.
- R6: `fifo_rd` is a pulse one clock wide. It rises in the cycle after the enable that loads a user byte. It never pulses for a fill byte.
- R7: `fifo_empty`, `fifo_data`, `match_en` and `idle_char` are sampled only at a byte boundary. Changes to them in the middle of a byte leave that byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit clock enable: one line bit per pulse |
| fifo_empty | input | 1 | Transmit FIFO holds no user data |
| fifo_data | input | DATA_W | Head byte of the transmit FIFO (first-word fall-through) |
| fifo_rd | output | 1 | One-cycle pop strobe for the FIFO |
| match_en | input | 1 | Pattern-match mode: selects the programmable idle fill |
| idle_char | input | DATA_W | Programmable idle character (host side resets it to all ones) |
| tx_bit | output | 1 | Serial line output, registered |

## Verification
The bench builds the block with DATA_W=8, the width of a byte. At this width the byte values that matter for framing can be used directly: 8'h7E, 8'hFF and 8'h00. It also keeps the number of bits per byte small enough for phases to be short:
- Enable on every cycle, so loads happen back to back.
- Enable on every third cycle, which tests the hold behaviour.
- Inputs changed in the middle of a byte.
- A long random run that mixes pushes, mode changes and enable gaps.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    SRC_USER = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_ONES = 2'd2
  } src_kind_e;
endpackage

// File: rtl/ctx_fill_sel.sv
module ctx_fill_sel
  import ctx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              match_en,
  input  logic [DATA_W-1:0] idle_char,
  output logic [DATA_W-1:0] src_byte,
  output logic              src_user
);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  src_kind_e kind;

  always_comb begin
    if (!fifo_empty)   kind = SRC_USER;
    else if (match_en) kind = SRC_IDLE;
    else               kind = SRC_ONES;
  end

  always_comb begin
    unique case (kind)
      SRC_USER: src_byte = fifo_data;
      SRC_IDLE: src_byte = idle_char;
      default:  src_byte = ONES;
    endcase
  end

  assign src_user = (kind == SRC_USER);
endmodule

// File: rtl/ctx_bit_ctr.sv
module ctx_bit_ctr #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic at_last
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= LAST;
    end else if (step) begin
      if (pos == LAST) pos <= '0;
      else             pos <= pos + 1'b1;
    end
  end

  assign at_last = (pos == LAST);
endmodule

// File: rtl/ctx_shifter.sv
module ctx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              load_user,
  output logic              tx_bit,
  output logic              rd_pulse
);
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '1;
      tx_bit   <= 1'b1;
      rd_pulse <= 1'b0;
    end else begin
      rd_pulse <= step && load && load_user;
      if (step) begin
        if (load) begin
          tx_bit <= load_byte[0];
          sreg   <= {1'b1, load_byte[DATA_W-1:1]};
        end else begin
          tx_bit <= sreg[0];
          sreg   <= {1'b1, sreg[DATA_W-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/clear_channel_tx.sv
module clear_channel_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  input  logic              match_en,
  input  logic [DATA_W-1:0] idle_char,
  output logic              tx_bit
);
  logic              at_last;
  logic [DATA_W-1:0] src_byte;
  logic              src_user;

  ctx_fill_sel #(.DATA_W(DATA_W)) u_sel (
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .match_en   (match_en),
    .idle_char  (idle_char),
    .src_byte   (src_byte),
    .src_user   (src_user)
  );

  ctx_bit_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .step    (bit_en),
    .at_last (at_last)
  );

  ctx_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk       (clk),
    .rst       (rst),
    .step      (bit_en),
    .load      (at_last),
    .load_byte (src_byte),
    .load_user (src_user),
    .tx_bit    (tx_bit),
    .rd_pulse  (fifo_rd)
  );
endmodule

// File: rtl/ctx_checker.sv
module ctx_checker #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic tx_bit
);
  logic [15:0] en_since_rd;
  logic        rd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_since_rd <= '0;
      rd_seen     <= 1'b0;
    end else if (fifo_rd) begin
      en_since_rd <= bit_en ? 16'd1 : 16'd0;
      rd_seen     <= 1'b1;
    end else if (bit_en && en_since_rd != 16'hFFFF) begin
      en_since_rd <= en_since_rd + 16'd1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tx_bit && !fifo_rd));

  a_r2_hold_without_en: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |=> !fifo_rd);

  a_r6_rd_follows_user_load: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> ($past(bit_en) && !$past(fifo_empty)));

  a_r7_rd_one_per_byte: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (!rd_seen || en_since_rd >= 16'(DATA_W)));
endmodule

bind clear_channel_tx ctx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .tx_bit     (tx_bit)
);

// File: tb/clear_channel_tx_bench.sv
`timescale 1ns/1ps
module clear_channel_tx_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_en = 1'b0;
  logic         fifo_empty = 1'b1;
  logic [W-1:0] fifo_data = '0;
  logic         fifo_rd;
  logic         match_en = 1'b0;
  logic [W-1:0] idle_char = 8'hFF;
  logic         tx_bit;

  always #2 clk = ~clk;

  clear_channel_tx #(.DATA_W(W)) u_clear_channel_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .match_en(match_en),
    .idle_char(idle_char), .tx_bit(tx_bit)
  );

  logic [W-1:0] q[$];
  int           vecs = 0;
  int           errs = 0;
  bit           done = 1'b0;
  string        req = "R1";

  int           m_pos = W - 1;
  logic [W-1:0] m_cur = '1;
  logic         e_bit = 1'b1;
  logic         e_rd = 1'b0;

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0] : '0;
  endtask

  task automatic push(input logic [W-1:0] b);
    q.push_back(b);
    refresh();
  endtask

  task automatic check();
    vecs++;
    if (tx_bit !== e_bit) begin
      errs++;
      $display("FAIL %s tx_bit actual=%b expected=%b t=%0t", req, tx_bit, e_bit, $time);
    end
    vecs++;
    if (fifo_rd !== e_rd) begin
      errs++;
      $display("FAIL %s fifo_rd actual=%b expected=%b t=%0t", req, fifo_rd, e_rd, $time);
    end
  endtask

  // one clock: drive enable, predict at the edge, compare after it
  task automatic tick(input logic en);
    logic [W-1:0] src;
    bit_en = en;
    @(posedge clk);
    e_rd = 1'b0;
    if (en) begin
      if (m_pos == W - 1) begin
        if (q.size() != 0) begin
          src  = q[0];
          e_rd = 1'b1;
        end else if (match_en) begin
          src = idle_char;
        end else begin
          src = '1;
        end
        m_cur = src;
        m_pos = 0;
      end else begin
        m_pos++;
      end
      e_bit = m_cur[m_pos];
    end
    @(negedge clk);
    check();
    if (fifo_rd) begin
      if (q.size() != 0) void'(q.pop_front());
      refresh();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    refresh();
    repeat (3) @(negedge clk);
    req = "R1";
    check();
    rst = 1'b0;
    @(negedge clk);
    check();

    // R5: ones fill ignores the idle register
    req = "R5";
    match_en = 1'b0; idle_char = 8'h3C;
    repeat (24) tick(1'b1);

    // R4: programmable idle fill
    req = "R4";
    match_en = 1'b1; idle_char = 8'hA5;
    repeat (24) tick(1'b1);

    // R3 / R6: framing-looking bytes back to back, enable every cycle
    req = "R3";
    push(8'h7E); push(8'hFF); push(8'h00); push(8'h81); push(8'hFF); push(8'h3E);
    repeat (64) tick(1'b1);

    // R2: sparse enables, output must hold between them
    req = "R2";
    push(8'h96); push(8'h01); push(8'h80);
    for (int i = 0; i < 90; i++) tick(i % 3 == 0);

    // R7: mid-byte changes do not touch the byte in progress
    req = "R7";
    match_en = 1'b1; idle_char = 8'hC3;
    while (m_pos != W - 1) tick(1'b1);
    tick(1'b1);
    tick(1'b1);
    match_en = 1'b0; idle_char = 8'h0F;
    tick(1'b1);
    push(8'h55);
    repeat (3) tick(1'b1);
    match_en = 1'b1;
    repeat (20) tick(1'b1);

    // R6: pulse only for user bytes, across a random mix
    req = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) push(8'($urandom));
      if ($urandom_range(0, 63) == 0) match_en = ~match_en;
      if ($urandom_range(0, 31) == 0) idle_char = 8'($urandom);
      tick($urandom_range(0, 3) != 0);
    end

    // R1: reset mid-byte returns to idle ones
    req = "R1";
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0;
    q.delete(); refresh();
    repeat (2) @(negedge clk);
    m_pos = W - 1; m_cur = '1; e_bit = 1'b1; e_rd = 1'b0;
    check();
    rst = 1'b0;
    match_en = 1'b0;
    @(negedge clk);
    check();
    repeat (10) tick(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule